// File: doc/BRIEF.md
# Exception Return Frame Unstacker

This block performs the memory side of a return-from-exception for a small 32-bit core. A one-cycle `start` pulse captures the current supervisor stack pointer and the address of the return instruction. The block then reads the frame header longword at that stack pointer and checks its 4-bit format code. A valid header restores the status register. The block then reads the return address from the next longword, pops the stack by a format-dependent amount and presents the new program counter.

A header with a format outside the accepted set is rejected. In that case the block raises a one-cycle format-error strobe together with `done`. It presents the return instruction's own address as the faulting PC and hands back the stack pointer unchanged. It issues no second read, and the status register keeps its old value. The block only reads memory, so the frame in memory is never disturbed.

The memory port allows one outstanding read. The block holds its request and address steady until `mem_ready` is seen high on a clock edge.

Top module: `xret_unstacker`

## Requirements
- R1: While `rst` is high and after it is released, `done`, `fmt_err` and `mem_req` are low, and `sp_o`, `sr_o` and `pc_o` are zero until the first sequence ends.
- R2: The first read is issued at the stack pointer that `sp_i` carried on the edge that accepted `start`. `mem_req` and `mem_addr` stay unchanged until an edge with `mem_ready` high.
- R3: The format code is bits 31:28 of the header longword. Only the values 4, 5, 6 and 7 are accepted. Every other value is a format error, and that includes any header with bit 30 clear.
- R4: For an accepted header, `sr_o` takes header bits 15:0 when the header read completes, which is before the second read is issued.
- R5: After an accepted header, exactly one further read is issued, at the captured stack pointer plus 4.
- R6: At the end of a valid sequence, `sp_o` equals the captured stack pointer plus 4 plus the format value. Format 4 therefore pops 8 bytes.
- R7: At the end of a valid sequence, `pc_o` equals the longword returned by the second read.
- R8: On a format error, `fmt_err` and `done` are both high for one cycle. `sp_o` equals the captured stack pointer, `pc_o` equals the `ret_pc_i` value captured at start, and `sr_o` is unchanged. No second read is issued.
- R9: `done` is a one-cycle pulse. Let L be the number of cycles the memory holds `mem_ready` low per read. `done` rises 2L+2 edges after the accepting edge for a valid frame, and L+1 edges after it for a rejected frame.
- R10: A `start` that arrives while a sequence is in progress is ignored. This includes the edge on which the last read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return sequence (accepted only when idle) |
| sp_i | input | 32 | Current supervisor stack pointer, captured at start |
| ret_pc_i | input | 32 | Address of the return instruction, captured at start |
| mem_req | output | 1 | Read request, held until ready |
| mem_addr | output | 32 | Read byte address |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read completes on an edge where this and mem_req are high |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fmt_err | output | 1 | One-cycle format-error request, high only with done |
| sp_o | output | 32 | Resulting stack pointer |
| sr_o | output | 16 | Restored status register |
| pc_o | output | 32 | New program counter, or faulting PC on error |

## Verification
Two events can land on the same edge: the completion of the final return-address read and a fresh `start` request. The bench holds `start` high through the whole sequence and on the final-ready edge. While it does so, it swaps `sp_i` to an unrelated address. It judges the result by checking three things: the pop uses the original pointer, `done` pulses exactly once, and `mem_req` stays low for the following cycles.

// File: rtl/xret_pkg.sv
package xret_pkg;
    localparam int WORD_W     = 32;
    localparam int SR_W       = 16;
    localparam int FMT_W      = 4;
    localparam int WORD_BYTES = 4;
    localparam int RSVD_W     = WORD_W - FMT_W - SR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SR_W-1:0]   sr_t;
    typedef logic [FMT_W-1:0]  fmt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_RET  = 2'd2
    } st_e;

    typedef struct packed {
        fmt_t                    fmt;
        logic [RSVD_W-1:0]       rsvd;
        sr_t                     sr;
    } hdr_t;

    // Accepted formats are 4..7: top bit clear, next bit set.
    function automatic logic fmt_ok(input fmt_t f);
        return (f[FMT_W-1] == 1'b0) && (f[FMT_W-2] == 1'b1);
    endfunction

    function automatic hdr_t hdr_unpack(input word_t w);
        return hdr_t'(w);
    endfunction
endpackage

// File: rtl/xret_fmt_check.sv
module xret_fmt_check
    import xret_pkg::*;
(
    input  word_t hdr_word,
    output hdr_t  hdr,
    output logic  hdr_ok
);
    always_comb begin
        hdr    = hdr_unpack(hdr_word);
        hdr_ok = fmt_ok(hdr.fmt);
    end
endmodule

// File: rtl/xret_sp_adj.sv
module xret_sp_adj
    import xret_pkg::*;
(
    input  word_t base,
    input  fmt_t  fmt,
    output word_t ret_addr,
    output word_t popped
);
    always_comb begin
        ret_addr = base + word_t'(WORD_BYTES);
        popped   = ret_addr + word_t'(fmt);
    end
endmodule

// File: rtl/xret_fsm.sv
module xret_fsm
    import xret_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mem_ready,
    input  logic hdr_ok,
    output st_e  st,
    output logic accept,
    output logic hdr_take,
    output logic err_take,
    output logic ret_take
);
    st_e st_q;
    st_e st_d;

    always_comb begin
        accept   = (st_q == ST_IDLE) && start;
        hdr_take = (st_q == ST_HDR) && mem_ready && hdr_ok;
        err_take = (st_q == ST_HDR) && mem_ready && !hdr_ok;
        ret_take = (st_q == ST_RET) && mem_ready;
        st_d     = st_q;
        unique case (st_q)
            ST_IDLE: if (accept)              st_d = ST_HDR;
            ST_HDR:  if (hdr_take)            st_d = ST_RET;
                     else if (err_take)       st_d = ST_IDLE;
            ST_RET:  if (ret_take)            st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign st = st_q;

    // R5: the return-address phase is only entered from the header phase
    p_ret_from_hdr_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> (st_q != ST_RET));

    // R10: a busy sequence never restarts into the header phase from the return phase
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RET) |=> (st_q != ST_HDR));
endmodule

// File: rtl/xret_unstacker.sv
module xret_unstacker
    import xret_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] sp_i,
    input  logic [31:0] ret_pc_i,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    output logic        done,
    output logic        fmt_err,
    output logic [31:0] sp_o,
    output logic [15:0] sr_o,
    output logic [31:0] pc_o
);
    st_e   st;
    logic  accept, hdr_take, err_take, ret_take;
    hdr_t  hdr;
    logic  hdr_ok;
    word_t ret_addr, popped;

    word_t sp_base_q, retpc_q, sp_q, pc_q;
    fmt_t  fmt_q;
    sr_t   sr_q;
    logic  done_q, err_q;

    xret_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mem_ready(mem_ready),
        .hdr_ok   (hdr_ok),
        .st       (st),
        .accept   (accept),
        .hdr_take (hdr_take),
        .err_take (err_take),
        .ret_take (ret_take)
    );

    xret_fmt_check u_chk (
        .hdr_word(mem_rdata),
        .hdr     (hdr),
        .hdr_ok  (hdr_ok)
    );

    xret_sp_adj u_adj (
        .base    (sp_base_q),
        .fmt     (fmt_q),
        .ret_addr(ret_addr),
        .popped  (popped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_base_q <= '0;
            retpc_q   <= '0;
            fmt_q     <= '0;
            sp_q      <= '0;
            sr_q      <= '0;
            pc_q      <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (accept) begin
                sp_base_q <= sp_i;
                retpc_q   <= ret_pc_i;
            end
            if (hdr_take) begin
                sr_q  <= hdr.sr;
                fmt_q <= hdr.fmt;
            end
            if (err_take) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
                sp_q   <= sp_base_q;
                pc_q   <= retpc_q;
            end
            if (ret_take) begin
                done_q <= 1'b1;
                sp_q   <= popped;
                pc_q   <= mem_rdata;
            end
        end
    end

    assign mem_req  = (st != ST_IDLE);
    assign mem_addr = (st == ST_RET) ? ret_addr : sp_base_q;
    assign done     = done_q;
    assign fmt_err  = err_q;
    assign sp_o     = sp_q;
    assign sr_o     = sr_q;
    assign pc_o     = pc_q;

    // R2: request and address hold while memory is not ready
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready && st == ST_HDR) |=> (mem_req && $stable(mem_addr)));

    // R8: format error only ever comes with done
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> done);

    // R8: rejected frame leaves the stack pointer where it was
    p_err_sp_kept_r8: assert property (@(posedge clk) disable iff (rst)
        fmt_err |-> (sp_o == sp_base_q));

    // R6: a valid pop is 8 to 11 bytes above the captured pointer
    p_pop_range_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !fmt_err) |-> ((sp_o - sp_base_q) >= 32'd8 && (sp_o - sp_base_q) <= 32'd11));

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: captured pointer cannot move while a read is outstanding
    p_base_hold_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> $stable(sp_base_q));
endmodule

// File: tb/xret_unstacker_tb_top.sv
module xret_unstacker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    localparam logic [31:0] VSP [NVEC] = '{
        32'h0000_1000, 32'h0000_2000, 32'h0000_3000, 32'h0000_4000,
        32'h0000_5000, 32'h0000_6000, 32'h0000_7000, 32'h0000_7FF0};
    localparam logic [31:0] VW1 [NVEC] = '{
        32'h4000_2704, 32'h5123_0011, 32'h6000_ABCD, 32'h7FFF_FFFF,
        32'h2000_1111, 32'h8000_2222, 32'h0000_3333, 32'h3FFF_0001};
    localparam logic [31:0] VW2 [NVEC] = '{
        32'h0000_5A00, 32'h0001_0000, 32'h0000_1234, 32'h8888_0000,
        32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444};
    localparam int VLAT [NVEC] = '{0, 1, 2, 0, 1, 0, 2, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] sp_i = '0;
    logic [31:0] ret_pc_i = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        done, fmt_err;
    logic [31:0] sp_o, pc_o;
    logic [15:0] sr_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] cur_sp = '0, cur_w1 = '0, cur_w2 = '0;
    int          cur_lat = 0;
    int          wcnt;
    logic        log_clr = 1'b0;
    int          nrd;
    logic [31:0] rd_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    xret_unstacker dut_i (
        .clk(clk), .rst(rst), .start(start), .sp_i(sp_i), .ret_pc_i(ret_pc_i),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .done(done), .fmt_err(fmt_err),
        .sp_o(sp_o), .sr_o(sr_o), .pc_o(pc_o));

    assign mem_ready = mem_req && (wcnt == cur_lat);
    assign mem_rdata = (mem_addr == cur_sp) ? cur_w1 :
                       (mem_addr == cur_sp + 32'd4) ? cur_w2 : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (rst || !mem_req || mem_ready) wcnt <= 0;
        else                              wcnt <= wcnt + 1;
        if (log_clr) nrd <= 0;
        else if (mem_req && mem_ready) begin
            if (nrd < 4) rd_log[nrd] <= mem_addr;
            nrd <= nrd + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts a sequence, returns edges from the accepting edge to done.
    task automatic run_seq(input logic [31:0] sp, input logic [31:0] w1,
                           input logic [31:0] w2, input int lat,
                           input logic [31:0] rpc, output int edges);
        @(negedge clk);
        cur_sp = sp; cur_w1 = w1; cur_w2 = w2; cur_lat = lat;
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1; sp_i = sp; ret_pc_i = rpc;
        @(posedge clk);
        edges = 0;
        while (edges < 64) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0; sp_i = 32'hFFFF_0000; ret_pc_i = 32'hFFFF_FFF0;
            if (done) break;
        end
    endtask

    logic [15:0] exp_sr = '0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 fmt_err", {31'd0, fmt_err}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sp_o", sp_o, 32'd0);
        chk("R1 pc_o", pc_o, 32'd0);
        chk("R1 sr_o", {16'd0, sr_o}, 32'd0);
        chk("R1 mem_req idle", {31'd0, mem_req}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  f;
            logic        ok;
            logic [31:0] rpc;
            int          e;
            f   = VW1[i][31:28];
            ok  = (f >= 4'd4) && (f <= 4'd7);
            rpc = 32'h0100_0000 + 32'(i) * 32'd16;
            run_seq(VSP[i], VW1[i], VW2[i], VLAT[i], rpc, e);
            // R9: latency by outcome
            chk("R9 latency", 32'(e), ok ? 32'(2*VLAT[i]+2) : 32'(VLAT[i]+1));
            // R3: format decision
            chk("R3 fmt_err", {31'd0, fmt_err}, {31'd0, !ok});
            chk("R2 first read addr", rd_log[0], VSP[i]);
            if (ok) begin
                exp_sr = VW1[i][15:0];
                chk("R5 second read addr", rd_log[1], VSP[i] + 32'd4);
                chk("R5 read count", 32'(nrd), 32'd2);
                chk("R6 sp_o", sp_o, VSP[i] + 32'd4 + 32'(f));
                chk("R7 pc_o", pc_o, VW2[i]);
                chk("R4 sr_o", {16'd0, sr_o}, {16'd0, exp_sr});
            end else begin
                chk("R8 read count", 32'(nrd), 32'd1);
                chk("R8 sp_o", sp_o, VSP[i]);
                chk("R8 pc_o", pc_o, rpc);
                chk("R8 sr_o", {16'd0, sr_o}, {16'd0, exp_sr});
            end
            @(negedge clk);
            chk("R9 done one cycle", {31'd0, done}, 32'd0);
            chk("R8 fmt_err one cycle", {31'd0, fmt_err}, 32'd0);
        end

        // R10: start held through the whole sequence, including the final-ready edge
        begin
            int e;
            int extra_done;
            int extra_req;
            @(negedge clk);
            cur_sp = 32'h0000_9000; cur_w1 = 32'h4000_0010; cur_w2 = 32'hCAFE_0000; cur_lat = 2;
            log_clr = 1'b1;
            @(negedge clk);
            log_clr = 1'b0;
            start = 1'b1; sp_i = 32'h0000_9000; ret_pc_i = 32'h0200_0000;
            @(posedge clk);
            e = 0;
            while (e < 64) begin
                @(posedge clk);
                e++;
                @(negedge clk);
                sp_i = 32'hAAAA_0000;
                if (done) begin start = 1'b0; break; end
                start = 1'b1;
            end
            chk("R10 latency with start held", 32'(e), 32'd6);
            chk("R10 sp from first capture", sp_o, 32'h0000_9008);
            chk("R10 pc", pc_o, 32'hCAFE_0000);
            chk("R10 read count", 32'(nrd), 32'd2);
            extra_done = 0; extra_req = 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done) extra_done++;
                if (mem_req) extra_req++;
            end
            chk("R10 no second done", 32'(extra_done), 32'd0);
            chk("R10 no restart request", 32'(extra_req), 32'd0);
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R9 actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule